// File: doc/BRIEF.md
# Transceiver Mode and Channel Sequencer

This block drives a half-duplex radio module. It controls the module power switch and two active-low selects, one for the receiver and one for the transmitter. It hands channel programming to a separate synthesizer loader through a request/done pair and watches the lock-detect line. Higher-level logic sends it three one-cycle commands: change channel, go to transmit and go to receive. The block then tells the modem when received data can be trusted (`rxReady`) and when payload can be sent (`txReady`).

All waiting is counted in ticks of an internal millisecond prescaler. The prescaler restarts at every state change, so each delay is exact in clock cycles. The first channel load after power-up gets a longer settle time than later loads. Channel changes are accepted only while the receiver is selected. After entering transmit, the block first emits an alternating preamble. If lock detect is low at the check point, the channel is treated as unusable.

Top module: `radio_seq_top`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `pwrEn` is 0 and both selects are 1. `pwrEn` goes to 1 one cycle later. `rxSelN` goes to 0 one cycle after that, and the block is then idle in receive with no channel.
- R2: A select is active when low. `rxSelN` and `txSelN` are never both 0. Every change of mode passes through exactly one cycle with both selects at 1.
- R3: `chanReq` is accepted only in receive (idle or ready). `loadReq` rises in the next cycle and stays at 1 until `loadDone` is sampled. While `loadReq` is 1, `rxReady` is 0 and the receiver stays selected.
- R4: For the first channel load after reset, `rxReady` rises FIRST_LOAD_MS*CLK_PER_MS+1 cycles after the edge that samples `loadDone`.
- R5: For every later channel load, `rxReady` rises NEXT_LOAD_MS*CLK_PER_MS+1 cycles after that edge.
- R6: Lock detect is sampled only in the cycle in which LOCK_CHECK_MS milliseconds have elapsed since `loadDone`, so earlier glitches have no effect. If it is low then, `lockFail` is 1 from the next cycle, `rxReady` stays 0 and the block returns to receive idle.
- R7: `txReq` in receive-ready gives a gap cycle and then `txSelN`=0. `preambleOn` rises MODE_SWITCH_MS*CLK_PER_MS+2 cycles after the request edge, with `preambleBit` starting at 1 and toggling every cycle. `txReady` rises PREAMBLE_MS*CLK_PER_MS+1 cycles after `preambleOn`, at the same edge where `preambleOn` falls.
- R8: `rxReq` in any transmit state gives a gap cycle and then `rxSelN`=0. `rxReady` rises MODE_SWITCH_MS*CLK_PER_MS+2 cycles after the request edge.
- R9: `chanReq` while the transmitter is selected is rejected. `chanErr` is 1 from the next cycle and transmit continues unchanged. `chanErr` and `lockFail` are both cleared when a channel change is next accepted.
- R10: `txReq` in receive idle (no valid channel) and `rxReq` in receive are ignored: the selects and `rxReady` do not change.
- R11: If `chanReq` and `txReq` arrive in the same cycle in receive-ready, the channel change wins and the transmitter is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chanReq | input | 1 | One-cycle channel-change command |
| txReq | input | 1 | One-cycle switch-to-transmit command |
| rxReq | input | 1 | One-cycle switch-to-receive command |
| loadDone | input | 1 | Loader finished programming the synthesizer |
| lockDet | input | 1 | Synthesizer lock detect, high when locked |
| pwrEn | output | 1 | Module power switch enable |
| rxSelN | output | 1 | Receiver select, active low |
| txSelN | output | 1 | Transmitter select, active low |
| loadReq | output | 1 | Request to the synthesizer loader |
| rxReady | output | 1 | Received data is valid |
| txReady | output | 1 | Payload may be transmitted |
| preambleOn | output | 1 | Preamble phase of transmit is running |
| preambleBit | output | 1 | Alternating preamble bit |
| chanErr | output | 1 | Channel change was rejected in transmit |
| lockFail | output | 1 | Lock detect was low at the check point |

## Verification
The bench builds the block with CLK_PER_MS=8 and keeps the nominal millisecond counts of 40, 20, 20, 5 and 15. This keeps every delay under a few hundred cycles while preserving their ratios. The short prescaler makes it possible to measure each wait with a cycle-exact edge count. It also lets the random phase chain many channel loads, lock failures and transmit/receive round trips. Because the lock check point and the later settle point fall in the same millisecond, the run also covers the case where a failed check must win over readiness.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;

  typedef enum logic [3:0] {
    S_INIT,
    S_PWR,
    S_RX_IDLE,
    S_LOAD,
    S_SETTLE,
    S_RX_READY,
    S_GAP_TX,
    S_TX_SW,
    S_TX_PRE,
    S_TX_READY,
    S_GAP_RX,
    S_RX_SW
  } seq_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic timerClr;
    logic preToggle;
    logic setChanErr;
    logic setLockFail;
    logic clrFlags;
  } dp_ctl_t;

endpackage

// File: rtl/radio_seq_dp.sv
module radio_seq_dp
  import radio_seq_pkg::*;
#(
  parameter int CLK_PER_MS = 50000,
  parameter int MS_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  dp_ctl_t         ctl,
  output logic [MS_W-1:0] msCount,
  output logic            msEdge,
  output logic            preBit,
  output logic            chanErr,
  output logic            lockFail
);

  localparam int PS_W = $clog2(CLK_PER_MS + 1);
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(CLK_PER_MS - 1);
  localparam logic [MS_W-1:0] MS_SAT = '1;

  logic [PS_W-1:0] psCnt;
  logic            tick;

  assign tick = (psCnt == PS_LAST);

  // millisecond prescaler and elapsed-ms counter, restarted on state change
  always_ff @(posedge clk) begin
    if (!rst_n || ctl.timerClr) begin
      psCnt   <= '0;
      msCount <= '0;
      msEdge  <= 1'b0;
    end else begin
      msEdge <= tick;
      if (tick) begin
        psCnt <= '0;
        if (msCount != MS_SAT) msCount <= msCount + 1'b1;
      end else begin
        psCnt <= psCnt + 1'b1;
      end
    end
  end

  // alternating preamble bit, starts at 1 on state entry
  always_ff @(posedge clk) begin
    if (!rst_n || ctl.timerClr) preBit <= 1'b1;
    else if (ctl.preToggle)     preBit <= ~preBit;
  end

  // sticky flags
  always_ff @(posedge clk) begin
    if (!rst_n || ctl.clrFlags) begin
      chanErr  <= 1'b0;
      lockFail <= 1'b0;
    end else begin
      if (ctl.setChanErr)  chanErr  <= 1'b1;
      if (ctl.setLockFail) lockFail <= 1'b1;
    end
  end

endmodule

// File: rtl/radio_seq_ctrl.sv
module radio_seq_ctrl
  import radio_seq_pkg::*;
#(
  parameter int FIRST_LOAD_MS  = 40,
  parameter int NEXT_LOAD_MS   = 20,
  parameter int LOCK_CHECK_MS  = 20,
  parameter int MODE_SWITCH_MS = 5,
  parameter int PREAMBLE_MS    = 15,
  parameter int MS_W           = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chanReq,
  input  logic            txReq,
  input  logic            rxReq,
  input  logic            loadDone,
  input  logic            lockDet,
  input  logic [MS_W-1:0] msCount,
  input  logic            msEdge,
  output dp_ctl_t         ctl,
  output logic            pwrEn,
  output logic            rxSelN,
  output logic            txSelN,
  output logic            loadReq,
  output logic            rxReady,
  output logic            txReady,
  output logic            preambleOn
);

  localparam logic [MS_W-1:0] T_FIRST = MS_W'(FIRST_LOAD_MS);
  localparam logic [MS_W-1:0] T_NEXT  = MS_W'(NEXT_LOAD_MS);
  localparam logic [MS_W-1:0] T_LOCK  = MS_W'(LOCK_CHECK_MS);
  localparam logic [MS_W-1:0] T_SW    = MS_W'(MODE_SWITCH_MS);
  localparam logic [MS_W-1:0] T_PRE   = MS_W'(PREAMBLE_MS);

  seq_state_e state, nextState;
  logic firstPending;
  logic longSettle;
  logic [MS_W-1:0] settleTarget;
  logic inTx;

  assign settleTarget = longSettle ? T_FIRST : T_NEXT;
  assign inTx = (state == S_TX_SW) || (state == S_TX_PRE) || (state == S_TX_READY);

  always_comb begin
    nextState = state;
    ctl       = '0;
    case (state)
      S_INIT:    nextState = S_PWR;
      S_PWR:     nextState = S_RX_IDLE;
      S_RX_IDLE: if (chanReq) begin
                   nextState    = S_LOAD;
                   ctl.clrFlags = 1'b1;
                 end
      S_LOAD:    if (loadDone) nextState = S_SETTLE;
      S_SETTLE:  if (msEdge && msCount == T_LOCK && !lockDet) begin
                   nextState       = S_RX_IDLE;
                   ctl.setLockFail = 1'b1;
                 end else if (msEdge && msCount == settleTarget) begin
                   nextState = S_RX_READY;
                 end
      S_RX_READY: if (chanReq) begin
                    nextState    = S_LOAD;
                    ctl.clrFlags = 1'b1;
                  end else if (txReq) begin
                    nextState = S_GAP_TX;
                  end
      S_GAP_TX:  nextState = S_TX_SW;
      S_TX_SW:   if (rxReq) nextState = S_GAP_RX;
                 else if (msEdge && msCount == T_SW) nextState = S_TX_PRE;
      S_TX_PRE:  if (rxReq) nextState = S_GAP_RX;
                 else if (msEdge && msCount == T_PRE) nextState = S_TX_READY;
      S_TX_READY: if (rxReq) nextState = S_GAP_RX;
      S_GAP_RX:  nextState = S_RX_SW;
      S_RX_SW:   if (msEdge && msCount == T_SW) nextState = S_RX_READY;
      default:   nextState = S_INIT;
    endcase
    if (inTx && chanReq) ctl.setChanErr = 1'b1;
    ctl.timerClr  = (nextState != state);
    ctl.preToggle = (state == S_TX_PRE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_INIT;
      firstPending <= 1'b1;
      longSettle   <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_LOAD && loadDone) begin
        longSettle   <= firstPending;
        firstPending <= 1'b0;
      end
    end
  end

  // Moore output decode
  always_comb begin
    pwrEn      = (state != S_INIT);
    rxSelN     = 1'b1;
    txSelN     = 1'b1;
    loadReq    = (state == S_LOAD);
    rxReady    = (state == S_RX_READY);
    txReady    = (state == S_TX_READY);
    preambleOn = (state == S_TX_PRE);
    case (state)
      S_RX_IDLE, S_LOAD, S_SETTLE, S_RX_READY, S_RX_SW: rxSelN = 1'b0;
      S_TX_SW, S_TX_PRE, S_TX_READY:                    txSelN = 1'b0;
      default: ;
    endcase
  end

endmodule

// File: rtl/radio_seq_top.sv
module radio_seq_top
  import radio_seq_pkg::*;
#(
  parameter int CLK_PER_MS     = 50000,
  parameter int FIRST_LOAD_MS  = 40,
  parameter int NEXT_LOAD_MS   = 20,
  parameter int LOCK_CHECK_MS  = 20,
  parameter int MODE_SWITCH_MS = 5,
  parameter int PREAMBLE_MS    = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chanReq,
  input  logic txReq,
  input  logic rxReq,
  input  logic loadDone,
  input  logic lockDet,
  output logic pwrEn,
  output logic rxSelN,
  output logic txSelN,
  output logic loadReq,
  output logic rxReady,
  output logic txReady,
  output logic preambleOn,
  output logic preambleBit,
  output logic chanErr,
  output logic lockFail
);

  localparam int M1 = (FIRST_LOAD_MS > NEXT_LOAD_MS) ? FIRST_LOAD_MS : NEXT_LOAD_MS;
  localparam int M2 = (LOCK_CHECK_MS > MODE_SWITCH_MS) ? LOCK_CHECK_MS : MODE_SWITCH_MS;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int MAX_MS = (M3 > PREAMBLE_MS) ? M3 : PREAMBLE_MS;
  localparam int MS_W = $clog2(MAX_MS + 2);

  dp_ctl_t ctl;
  logic [MS_W-1:0] msCount;
  logic msEdge;
  logic preBit;

  radio_seq_ctrl #(
    .FIRST_LOAD_MS (FIRST_LOAD_MS),
    .NEXT_LOAD_MS  (NEXT_LOAD_MS),
    .LOCK_CHECK_MS (LOCK_CHECK_MS),
    .MODE_SWITCH_MS(MODE_SWITCH_MS),
    .PREAMBLE_MS   (PREAMBLE_MS),
    .MS_W          (MS_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .chanReq   (chanReq),
    .txReq     (txReq),
    .rxReq     (rxReq),
    .loadDone  (loadDone),
    .lockDet   (lockDet),
    .msCount   (msCount),
    .msEdge    (msEdge),
    .ctl       (ctl),
    .pwrEn     (pwrEn),
    .rxSelN    (rxSelN),
    .txSelN    (txSelN),
    .loadReq   (loadReq),
    .rxReady   (rxReady),
    .txReady   (txReady),
    .preambleOn(preambleOn)
  );

  radio_seq_dp #(
    .CLK_PER_MS(CLK_PER_MS),
    .MS_W      (MS_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .msCount (msCount),
    .msEdge  (msEdge),
    .preBit  (preBit),
    .chanErr (chanErr),
    .lockFail(lockFail)
  );

  assign preambleBit = preambleOn & preBit;

endmodule

// File: rtl/radio_seq_chk.sv
module radio_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic chanReq,
  input logic pwrEn,
  input logic rxSelN,
  input logic txSelN,
  input logic loadReq,
  input logic rxReady,
  input logic txReady,
  input logic preambleOn,
  input logic preambleBit,
  input logic chanErr,
  input logic lockFail
);

  a_r1_sel_off_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrEn |-> (rxSelN && txSelN));

  a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rxSelN && !txSelN));

  a_r2_gap_into_tx: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txSelN) |-> $past(rxSelN));

  a_r2_gap_into_rx: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxSelN) |-> $past(txSelN));

  a_r3_load_in_rx: assert property (@(posedge clk) disable iff (!rst_n)
    loadReq |-> (!rxSelN && txSelN && !rxReady));

  a_r6_fail_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    lockFail |-> !rxReady);

  a_r7_preamble_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (preambleOn && $past(preambleOn)) |-> (preambleBit != $past(preambleBit)));

  a_r7_tx_ready_selected: assert property (@(posedge clk) disable iff (!rst_n)
    txReady |-> (!txSelN && !preambleOn && !rxReady));

  a_r8_rx_ready_selected: assert property (@(posedge clk) disable iff (!rst_n)
    rxReady |-> !rxSelN);

  a_r9_reject_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (chanReq && !txSelN) |=> (chanErr && !loadReq));

endmodule

bind radio_seq_top radio_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chanReq    (chanReq),
  .pwrEn      (pwrEn),
  .rxSelN     (rxSelN),
  .txSelN     (txSelN),
  .loadReq    (loadReq),
  .rxReady    (rxReady),
  .txReady    (txReady),
  .preambleOn (preambleOn),
  .preambleBit(preambleBit),
  .chanErr    (chanErr),
  .lockFail   (lockFail)
);

// File: tb/sim_radio_seq_top.sv
module sim_radio_seq_top;

  localparam int CPM   = 8;
  localparam int FIRST = 40;
  localparam int NEXT  = 20;
  localparam int LOCK  = 20;
  localparam int SW    = 5;
  localparam int PRE   = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chanReq = 1'b0, txReq = 1'b0, rxReq = 1'b0, loadDone = 1'b0, lockDet = 1'b0;
  logic pwrEn, rxSelN, txSelN, loadReq, rxReady, txReady;
  logic preambleOn, preambleBit, chanErr, lockFail;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  radio_seq_top #(
    .CLK_PER_MS(CPM), .FIRST_LOAD_MS(FIRST), .NEXT_LOAD_MS(NEXT),
    .LOCK_CHECK_MS(LOCK), .MODE_SWITCH_MS(SW), .PREAMBLE_MS(PRE)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .chanReq(chanReq), .txReq(txReq), .rxReq(rxReq),
    .loadDone(loadDone), .lockDet(lockDet), .pwrEn(pwrEn), .rxSelN(rxSelN),
    .txSelN(txSelN), .loadReq(loadReq), .rxReady(rxReady), .txReady(txReady),
    .preambleOn(preambleOn), .preambleBit(preambleBit), .chanErr(chanErr),
    .lockFail(lockFail)
  );

  // expected timings, in edges after the sampling edge of the command
  function automatic int settleAt(bit first);
    return (first ? FIRST : NEXT) * CPM + 1;
  endfunction
  function automatic int preStartAt();
    return SW * CPM + 2;
  endfunction
  function automatic int txReadyAt();
    return (SW + PRE) * CPM + 3;
  endfunction
  function automatic int rxBackAt();
    return SW * CPM + 2;
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got=%0d exp=%0d", req, what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // channel load; withTx also raises txReq in the same cycle
  task automatic doLoad(input bit first, input bit lockOk, input bit glitch, input bit withTx);
    int d;
    int ex;
    chanReq = 1'b1;
    txReq   = withTx;
    step();
    chanReq = 1'b0;
    txReq   = 1'b0;
    chk("R3", "loadReq after chanReq", loadReq, 1);
    chk("R3", "rxReady during load", rxReady, 0);
    chk("R9", "flags cleared on accepted change", chanErr | lockFail, 0);
    if (withTx) begin
      chk("R11", "txSelN on chan+tx", txSelN, 1);
      chk("R11", "rxSelN on chan+tx", rxSelN, 0);
    end
    d = $urandom % 4;
    for (int i = 0; i < d; i++) begin
      step();
      chk("R3", "loadReq held", loadReq, 1);
    end
    loadDone = 1'b1;
    step();
    loadDone = 1'b0;
    chk("R3", "loadReq drops", loadReq, 0);
    ex = settleAt(first);
    for (int n = 0; n <= ex + 1; n++) begin
      if (lockOk) begin
        if (n == ex - 1) chk(first ? "R4" : "R5", "rxReady before settle", rxReady, 0);
        if (n == ex)     chk(first ? "R4" : "R5", "rxReady at settle", rxReady, 1);
      end else begin
        if (n == LOCK * CPM)     chk("R6", "lockFail before check", lockFail, 0);
        if (n == LOCK * CPM + 1) chk("R6", "lockFail after check", lockFail, 1);
        if (n == ex + 1) begin
          chk("R6", "rxReady after fail", rxReady, 0);
          chk("R6", "rx still selected", rxSelN, 0);
        end
      end
      if (glitch && n < LOCK * CPM - 1) lockDet = 1'($urandom % 2);
      else lockDet = lockOk;
      step();
    end
    lockDet = 1'b1;
  endtask

  task automatic doTx();
    txReq = 1'b1;
    step();
    txReq = 1'b0;
    for (int n = 0; n <= txReadyAt(); n++) begin
      if (n == 0) chk("R2", "gap before tx", {30'd0, rxSelN, txSelN}, 3);
      if (n == 1) chk("R7", "tx selected", {30'd0, rxSelN, txSelN}, 2);
      if (n == preStartAt() - 1) chk("R7", "preamble not yet", preambleOn, 0);
      if (n == preStartAt()) begin
        chk("R7", "preamble starts", preambleOn, 1);
        chk("R7", "preamble first bit", preambleBit, 1);
      end
      if (n == preStartAt() + 1) chk("R7", "preamble second bit", preambleBit, 0);
      if (n == preStartAt() + 2) chk("R7", "preamble third bit", preambleBit, 1);
      if (n == txReadyAt() - 1) chk("R7", "txReady before end", txReady, 0);
      if (n == txReadyAt()) begin
        chk("R7", "txReady after preamble", txReady, 1);
        chk("R7", "preamble ended", preambleOn, 0);
      end
      if (n < txReadyAt()) step();
    end
  endtask

  task automatic doRejectInTx();
    chanReq = 1'b1;
    step();
    chanReq = 1'b0;
    chk("R9", "chanErr set", chanErr, 1);
    chk("R9", "txReady kept", txReady, 1);
    chk("R9", "no load in tx", loadReq, 0);
  endtask

  task automatic doRx();
    rxReq = 1'b1;
    step();
    rxReq = 1'b0;
    for (int n = 0; n <= rxBackAt(); n++) begin
      if (n == 0) chk("R2", "gap before rx", {30'd0, rxSelN, txSelN}, 3);
      if (n == 1) chk("R8", "rx selected", {30'd0, rxSelN, txSelN}, 1);
      if (n == rxBackAt() - 1) chk("R8", "rxReady before switch", rxReady, 0);
      if (n == rxBackAt()) chk("R8", "rxReady after switch", rxReady, 1);
      if (n < rxBackAt()) step();
    end
  endtask

  task automatic txIgnoredIdle();
    txReq = 1'b1;
    step();
    txReq = 1'b0;
    step();
    step();
    chk("R10", "txReq ignored without channel", {30'd0, rxSelN, txSelN}, 1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    step();
    chk("R1", "power off in reset", pwrEn, 0);
    chk("R1", "selects off in reset", {30'd0, rxSelN, txSelN}, 3);
    rst_n = 1'b1;
    chk("R1", "power off first cycle", pwrEn, 0);
    step();
    chk("R1", "power on", pwrEn, 1);
    chk("R1", "selects still off", {30'd0, rxSelN, txSelN}, 3);
    step();
    chk("R1", "receive selected", {30'd0, rxSelN, txSelN}, 1);
    chk("R1", "not ready without channel", rxReady, 0);

    txIgnoredIdle();
    doLoad(1'b1, 1'b1, 1'b1, 1'b0);   // first load, glitching lock, R4/R6

    rxReq = 1'b1;
    step();
    rxReq = 1'b0;
    chk("R10", "rxReq in rx keeps ready", rxReady, 1);
    chk("R10", "rxReq in rx keeps select", rxSelN, 0);

    doTx();
    doRejectInTx();
    doRx();
    doLoad(1'b0, 1'b1, 1'b0, 1'b0);   // later load, R5
    doLoad(1'b0, 1'b0, 1'b1, 1'b0);   // lock failure, R6
    txIgnoredIdle();
    doLoad(1'b0, 1'b1, 1'b0, 1'b0);
    doLoad(1'b0, 1'b1, 1'b0, 1'b1);   // priority, R11

    for (int it = 0; it < 10; it++) begin
      int op;
      op = $urandom % 3;
      if (op == 0) begin
        bit ok;
        ok = ($urandom % 4) != 0;
        doLoad(1'b0, ok, 1'($urandom % 2), 1'b0);
        if (!ok) doLoad(1'b0, 1'b1, 1'b0, 1'b0);
      end else if (op == 1) begin
        doTx();
        if ($urandom % 2) doRejectInTx();
        doRx();
      end else begin
        doLoad(1'b0, 1'b1, 1'($urandom % 2), 1'b1);
      end
    end

    summary();
    $finish;
  end

endmodule